// File: doc/BRIEF.md
# Flash Toggle-Bit Status Poller

This block sits on the host side of a parallel NOR flash. It watches an embedded program or erase operation that has already been started. After a start pulse it reads the status byte from the flash through a simple request/acknowledge bus port. It compares bit 6 of two reads in a row. If the bit has changed, the device is still busy. If it has not changed, the operation has finished. Bit 5 is the device's own timeout flag. When that flag is set while bit 6 is still toggling, the block reads a second pair to check again, because the toggling may have stopped just as the flag came up.

A failed operation ends with one bus write of the reset command 0xF0. The poller waits for the acknowledge of that write, so the flash is back in array-read mode when the poller reports. A programmable limit on the number of busy read pairs guards against a device that never finishes. An abort input stops polling at once. The next start always begins with a fresh first read pair and a cleared pair count. The result appears as a one-cycle done pulse, with a fail flag that is valid in the same cycle.

Top module: `nor_status_poller`

## Requirements
- R1: After reset, and whenever the poller is idle, bus_req, busy, done and fail are all 0.
- R2: An accepted start begins read transfers with bus_we=0 at the poll_addr value captured at start. A transfer completes in a cycle where bus_req and bus_ack are both 1. While bus_ack is 0 and there is no abort, bus_req, bus_we and bus_addr are held stable.
- R3: The reads come in pairs. If bit 6 (mask 0x40) has the same value in both reads of a pair, the poller finishes with success (fail=0) and makes no write. Bits 7 and 4..0 have no effect.
- R4: If bit 6 differs within a pair and bit 5 (mask 0x20) of the second read is 0, the poller starts another read pair, unless the R7 limit is reached.
- R5: If bit 6 differs within a pair and bit 5 of the second read is 1, the poller reads one more recheck pair. If bit 6 is equal within the recheck pair, the result is success.
- R6: If bit 6 still differs within the recheck pair, the poller makes exactly one write of 0xF0 to the captured address. It then reports failure (fail=1) after that write is acknowledged.
- R7: Let M be max_iter, with 0 treated as 1. The M-th read pair that toggles with bit 5 clear leads to the reset write of R6 and a failure result.
- R8: While abort is 1, the next cycle shows busy=0 and bus_req=0, and no done pulse results. A later start begins with a fresh first read pair and a cleared pair count.
- R9: A start pulse while busy is ignored. The read sequence and the result are the same as without that pulse.
- R10: done is a single-cycle pulse in the cycle after the acknowledge of the final transfer. fail is 1 only together with done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin polling (ignored while busy) |
| abort | input | 1 | Abandon polling and return to idle |
| max_iter | input | CNT_W | Limit on busy read pairs (0 acts as 1) |
| poll_addr | input | ADDR_W | Address used for status reads and the reset write |
| busy | output | 1 | Polling in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Failure result, valid with done |
| bus_req | output | 1 | Bus transfer request |
| bus_we | output | 1 | 1 = write transfer, 0 = read transfer |
| bus_addr | output | ADDR_W | Transfer address |
| bus_wdata | output | 8 | Write data (0xF0 on the reset write) |
| bus_ack | input | 1 | Transfer complete; read data is valid in this cycle |
| bus_rdata | input | 8 | Status byte read from the flash |

## Verification
Each transfer completes at the clock edge where bus_ack is sampled high. The done pulse, with its fail flag, is due exactly one cycle after the edge that completes the last read or the reset write. The bench drives bus_ack and bus_rdata on falling edges with 0 to 2 wait cycles. It logs the cycle of every acknowledge it issues and compares the cycle of the done pulse against that log plus one. After an abort, the bench checks busy and bus_req one cycle later and then watches several more cycles for a stray done pulse. It compares the read and write counts against a model of the pair rules. That model is swept over toggle lengths, bit-5 onsets and pair limits.

// File: rtl/nsp_pkg.sv
// Package: shared types and constants for the NOR status poller.
// Assumes an 8-bit status byte with the toggle indicator in bit 6 and the
// device timeout flag in bit 5.
package nsp_pkg;
    localparam int DATA_W = 8;
    localparam logic [DATA_W-1:0] TOGGLE_MASK = 8'h40;
    localparam logic [DATA_W-1:0] TMO_MASK    = 8'h20;
    localparam logic [DATA_W-1:0] RESET_CMD   = 8'hF0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_A,
        ST_RD_B,
        ST_RK_A,
        ST_RK_B,
        ST_WR_RST
    } nsp_state_e;
endpackage

// File: rtl/nsp_pair_eval.sv
// Module: combinational judge of one read pair.
// Reports whether the toggle bit differs between the two reads and whether
// the timeout flag is set in the second read. Assumes both bytes are valid
// in the cycle the sequencer samples the result.
module nsp_pair_eval
    import nsp_pkg::*;
(
    input  logic [DATA_W-1:0] first_byte,
    input  logic [DATA_W-1:0] second_byte,
    output logic              toggling,
    output logic              tmo_flag
);
    // Compare the toggle bit of the two reads and pick out the timeout flag.
    always_comb begin
        toggling = |((first_byte ^ second_byte) & TOGGLE_MASK);
        tmo_flag = |(second_byte & TMO_MASK);
    end
endmodule

// File: rtl/nsp_iter_guard.sv
// Module: counter of busy read pairs with a programmable limit.
// last_allowed is high when the next busy pair would reach the limit.
// A limit of zero is treated as one. Assumes clear has priority over bump.
module nsp_iter_guard #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             bump,
    input  logic [CNT_W-1:0] max_iter,
    output logic             last_allowed
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] eff_max;

    // Count the busy pairs seen since the last clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clear)
            cnt_q <= '0;
        else if (bump)
            cnt_q <= cnt_q + ONE;
    end

    // Compare the count of the next pair against the effective limit.
    always_comb begin
        eff_max      = (max_iter == '0) ? ONE : max_iter;
        last_allowed = ({1'b0, cnt_q} + {1'b0, ONE}) >= {1'b0, eff_max};
    end
endmodule

// File: rtl/nsp_seq.sv
// Module: sequencer of the toggle-bit algorithm.
// It walks through a read pair, an optional recheck pair and an optional
// reset write, and raises a one-cycle done with a fail flag. Assumes that
// bus_ack is only sampled while a transfer is requested, and that abort
// overrides everything.
module nsp_seq
    import nsp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              toggling,
    input  logic              tmo_flag,
    input  logic              last_allowed,
    output nsp_state_e        state,
    output logic [DATA_W-1:0] first_byte,
    output logic              accept,
    output logic              iter_clear,
    output logic              iter_bump,
    output logic              done,
    output logic              fail
);
    nsp_state_e state_q;

    // Decode start acceptance and the counter controls from the state.
    always_comb begin
        accept     = (state_q == ST_IDLE) && start && !abort;
        iter_clear = accept || abort;
        iter_bump  = (state_q == ST_RD_B) && bus_ack && !abort &&
                     toggling && !tmo_flag && !last_allowed;
    end

    // Advance the algorithm and register the completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            first_byte <= '0;
            done       <= 1'b0;
            fail       <= 1'b0;
        end else begin
            done <= 1'b0;
            fail <= 1'b0;
            if (abort) begin
                state_q <= ST_IDLE;
            end else begin
                case (state_q)
                    ST_IDLE: if (start) state_q <= ST_RD_A;
                    ST_RD_A: if (bus_ack) begin
                        first_byte <= bus_rdata;
                        state_q    <= ST_RD_B;
                    end
                    ST_RD_B: if (bus_ack) begin
                        if (!toggling) begin
                            done    <= 1'b1;
                            state_q <= ST_IDLE;
                        end else if (tmo_flag) begin
                            state_q <= ST_RK_A;
                        end else if (last_allowed) begin
                            state_q <= ST_WR_RST;
                        end else begin
                            state_q <= ST_RD_A;
                        end
                    end
                    ST_RK_A: if (bus_ack) begin
                        first_byte <= bus_rdata;
                        state_q    <= ST_RK_B;
                    end
                    ST_RK_B: if (bus_ack) begin
                        if (!toggling) begin
                            done    <= 1'b1;
                            state_q <= ST_IDLE;
                        end else begin
                            state_q <= ST_WR_RST;
                        end
                    end
                    ST_WR_RST: if (bus_ack) begin
                        done    <= 1'b1;
                        fail    <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    assign state = state_q;
endmodule

// File: rtl/nor_status_poller.sv
// Module: top of the NOR flash toggle-bit status poller.
// It wires the sequencer, the pair judge and the iteration guard. It drives
// the request/acknowledge bus port from the sequencer state. Assumes one
// transfer completes per cycle in which bus_req and bus_ack are both high.
module nor_status_poller
    import nsp_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic [CNT_W-1:0]  max_iter,
    input  logic [ADDR_W-1:0] poll_addr,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata
);
    nsp_state_e        state;
    logic [DATA_W-1:0] first_byte;
    logic              accept;
    logic              iter_clear;
    logic              iter_bump;
    logic              toggling;
    logic              tmo_flag;
    logic              last_allowed;
    logic [ADDR_W-1:0] addr_q;

    nsp_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .abort        (abort),
        .bus_ack      (bus_ack),
        .bus_rdata    (bus_rdata),
        .toggling     (toggling),
        .tmo_flag     (tmo_flag),
        .last_allowed (last_allowed),
        .state        (state),
        .first_byte   (first_byte),
        .accept       (accept),
        .iter_clear   (iter_clear),
        .iter_bump    (iter_bump),
        .done         (done),
        .fail         (fail)
    );

    nsp_pair_eval u_eval (
        .first_byte  (first_byte),
        .second_byte (bus_rdata),
        .toggling    (toggling),
        .tmo_flag    (tmo_flag)
    );

    nsp_iter_guard #(.CNT_W(CNT_W)) u_guard (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear        (iter_clear),
        .bump         (iter_bump),
        .max_iter     (max_iter),
        .last_allowed (last_allowed)
    );

    // Capture the poll address when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_q <= '0;
        else if (accept)
            addr_q <= poll_addr;
    end

    // Drive the bus port from the sequencer state.
    always_comb begin
        busy      = (state != ST_IDLE);
        bus_req   = busy;
        bus_we    = (state == ST_WR_RST);
        bus_addr  = addr_q;
        bus_wdata = bus_we ? RESET_CMD : '0;
    end
endmodule

// File: rtl/nsp_poller_chk.sv
// Module: checker for the NOR status poller, bound to the top module.
// Assumes a synchronous active-low reset; every property is disabled in reset.
module nsp_poller_chk #(
    parameter int ADDR_W = 22
) (
    input logic              clk,
    input logic              rst_n,
    input logic              abort,
    input logic              busy,
    input logic              done,
    input logic              fail,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic              bus_ack
);
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_req);

    a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack && !abort) |=>
            (bus_req && $stable(bus_we) && $stable(bus_addr)));

    a_r3_ok_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fail) |-> $past(bus_req && !bus_we && bus_ack));

    a_r6_write_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we) |-> (bus_wdata == 8'hF0));

    a_r6_fail_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fail) |-> $past(bus_req && bus_we && bus_ack));

    a_r8_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!busy && !bus_req && !done));

    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r10_fail_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> done);
endmodule

bind nor_status_poller nsp_poller_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .abort     (abort),
    .busy      (busy),
    .done      (done),
    .fail      (fail),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_ack   (bus_ack)
);

// File: tb/nor_status_poller_test.sv
`timescale 1ns/1ps
// Bench: sweeps a behavioural flash status model against the poller.
// The model makes bit 6 toggle on each of the first T reads and raises
// bit 5 from read index D onward. The responder acknowledges after L wait cycles.
module nor_status_poller_test;
    localparam int ADDR_W = 22;
    localparam int CNT_W  = 8;
    localparam int NEVER  = 99;
    localparam int CYC_LIMIT = 190000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              abort = 1'b0;
    logic [CNT_W-1:0]  max_iter = '0;
    logic [ADDR_W-1:0] poll_addr = '0;
    logic              busy, done, fail;
    logic              bus_req, bus_we;
    logic [ADDR_W-1:0] bus_addr;
    logic [7:0]        bus_wdata;
    logic              bus_ack = 1'b0;
    logic [7:0]        bus_rdata = '0;

    nor_status_poller #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
        .max_iter(max_iter), .poll_addr(poll_addr),
        .busy(busy), .done(done), .fail(fail),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // model and responder state
    int m_t = 0, m_d = NEVER, lat = 0;
    bit hold = 1'b0;
    int wait_c = 0;
    int rd_cnt = 0, wr_cnt = 0;
    bit rd_bad = 1'b0, wr_bad = 1'b0;
    int last_ack = -10, done_cnt = 0, done_at = -1;
    bit got_fail = 1'b0;
    logic [ADDR_W-1:0] exp_addr = '0;

    function automatic logic [7:0] status_byte(int n);
        int k;
        logic b6, b5;
        k  = (n < m_t) ? n : m_t;
        b6 = k[0];
        b5 = (n >= m_d);
        return {~n[0], b6, b5, n[4:0]};
    endfunction

    // Responder and monitor: acknowledges transfers and logs done pulses.
    always @(negedge clk) begin
        cyc++;
        if (done) begin
            done_cnt++;
            done_at  = cyc;
            got_fail = fail;
        end
        bus_ack = 1'b0;
        if (!rst_n || hold) begin
            wait_c = 0;
        end else if (bus_req) begin
            if (wait_c >= lat) begin
                bus_ack  = 1'b1;
                wait_c   = 0;
                last_ack = cyc;
                if (bus_we) begin
                    wr_cnt++;
                    if (bus_wdata != 8'hF0 || bus_addr != exp_addr) wr_bad = 1'b1;
                end else begin
                    bus_rdata = status_byte(rd_cnt);
                    rd_cnt++;
                    if (bus_addr != exp_addr) rd_bad = 1'b1;
                end
            end else begin
                wait_c++;
            end
        end else begin
            wait_c = 0;
        end
        if (cyc > CYC_LIMIT) begin
            errors++;
            $display("FAIL watchdog: run exceeded %0d cycles (actual %0d, expected below)", CYC_LIMIT, cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    // Reference model of the pair rules.
    task automatic predict(int t, int d, int mi, output bit efail,
                           output int ereads, output string tag);
        int n, c, eff;
        bit tog, b5;
        n = 0; c = 0; eff = (mi == 0) ? 1 : mi;
        efail = 1'b0; tag = "R3";
        for (int guard = 0; guard < 1000; guard++) begin
            tog = (n < t);
            b5  = ((n + 1) >= d);
            n   = n + 2;
            if (!tog) begin efail = 1'b0; tag = (n > 2) ? "R4" : "R3"; break; end
            if (b5) begin
                tog = (n < t);
                n   = n + 2;
                efail = tog;
                tag = tog ? "R6" : "R5";
                break;
            end
            if (c + 1 >= eff) begin efail = 1'b1; tag = "R7"; break; end
            c++;
        end
        ereads = n;
    endtask

    task automatic clear_logs();
        rd_cnt = 0; wr_cnt = 0; rd_bad = 1'b0; wr_bad = 1'b0;
        done_cnt = 0; done_at = -1; last_ack = -10; got_fail = 1'b0;
    endtask

    task automatic run_case(int t, int d, int mi, int l, logic [ADDR_W-1:0] a,
                            bit repulse);
        bit efail;
        int ereads;
        string tag;
        predict(t, d, mi, efail, ereads, tag);
        if (repulse) tag = "R9";
        m_t = t; m_d = d; lat = l;
        max_iter = CNT_W'(mi);
        poll_addr = a; exp_addr = a;
        clear_logs();
        start = 1'b1;
        step();
        start = 1'b0;
        poll_addr = ~a;
        for (int w = 0; w < 600 && done_cnt == 0; w++) begin
            if (repulse && (w == 1 || w == 4)) start = 1'b1;
            else start = 1'b0;
            step();
        end
        start = 1'b0;
        for (int w = 0; w < 3; w++) step();
        check(got_fail == efail, tag, "result fail flag", int'(got_fail), int'(efail));
        check(rd_cnt == ereads, tag, "read count", rd_cnt, ereads);
        check(wr_cnt == int'(efail), efail ? tag : "R3", "reset write count", wr_cnt, int'(efail));
        check(!wr_bad && !rd_bad, "R2", "address/data of transfers", int'(wr_bad || rd_bad), 0);
        check(done_cnt == 1 && done_at == last_ack + 1, "R10", "done pulse timing",
              done_at - last_ack, 1);
    endtask

    initial begin
        int eff_reads;
        for (int i = 0; i < 3; i++) step();
        // R1: reset state
        check(!busy && !bus_req && !done && !fail, "R1", "outputs in reset",
              int'({busy, bus_req, done, fail}), 0);
        rst_n = 1'b1;
        step();
        check(!busy && !bus_req && !done && !fail, "R1", "outputs idle after reset",
              int'({busy, bus_req, done, fail}), 0);

        // Sweep toggle length, bit-5 onset, pair limit and wait cycles.
        for (int l = 0; l < 3; l++)
            for (int mi = 0; mi < 4; mi++)
                for (int t = 0; t < 8; t++)
                    for (int di = 0; di < 10; di++)
                        run_case(t, (di == 9) ? NEVER : di, mi, l,
                                 ADDR_W'(t * 4097 + di * 131 + mi * 17 + l), 1'b0);

        // R9: extra start pulses while busy change nothing.
        for (int l = 0; l < 3; l++)
            for (int t = 3; t < 7; t++)
                run_case(t, NEVER, 10, l, ADDR_W'(22'h2A5A5 + t), 1'b1);

        // R8: abort mid-poll, then a fresh start with a cleared pair count.
        m_t = 1000; m_d = NEVER; lat = 1; max_iter = CNT_W'(3);
        poll_addr = 22'h01234; exp_addr = 22'h01234;
        clear_logs();
        start = 1'b1; step(); start = 1'b0;
        for (int w = 0; w < 100 && rd_cnt < 3; w++) step();
        hold = 1'b1;
        step();
        abort = 1'b1;
        step();
        abort = 1'b0;
        check(!busy && !bus_req, "R8", "idle one cycle after abort",
              int'({busy, bus_req}), 0);
        for (int w = 0; w < 6; w++) step();
        check(done_cnt == 0 && !busy, "R8", "no done pulse after abort", done_cnt, 0);
        hold = 1'b0;
        clear_logs();
        start = 1'b1; step(); start = 1'b0;
        for (int w = 0; w < 600 && done_cnt == 0; w++) step();
        for (int w = 0; w < 3; w++) step();
        eff_reads = 6;
        check(rd_cnt == eff_reads, "R8", "fresh pair count after restart", rd_cnt, eff_reads);
        check(got_fail == 1'b1 && wr_cnt == 1, "R8", "limit failure after restart",
              int'(got_fail) + wr_cnt, 2);

        check(!busy && !bus_req, "R1", "idle at end", int'({busy, bus_req}), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule